// File: doc/BRIEF.md
# I2C Paged Memory Target

This block is an I2C target that sits in front of a 512-byte memory array and a small bank of configuration registers. It samples the bus lines with the system clock, finds Start and Stop conditions and clock edges, and pulls SDA low through an open-drain output enable when it acknowledges a byte or sends a zero. A control byte picks one of two address spaces through a 4-bit type code, checks two bus-select bits against strap inputs, and for the memory carries the ninth address bit. The word-address byte that follows supplies the low eight address bits, or names a register in the configuration space.

Written bytes are gathered in a 16-entry page buffer. They reach the array or the registers only when a Stop ends the transfer on a byte boundary. The commit is followed by an internal write cycle of a set number of clocks, and during that time the target does not respond on the bus. A read loads its address with a write header, a repeated Start and a read header. Data comes back MSB first, and the address advances after each byte the controller acknowledges. The configuration registers are also driven onto a flat output port.

Top module: `i2cpm_slave`

## Requirements
- R1: After reset the SDA output enable is low and every configuration register reads zero on the register port.
- R2: A control byte is laid out as bits [7:4] type code, [3:2] bus-select bits, [1] ninth memory address bit, [0] direction (1 = read). The target acknowledges it only when the code is 4'b1010 (memory) or 4'b1011 (registers) and bits [3:2] equal the strap inputs. Otherwise it leaves SDA released and ignores the bus until the next Start, so nothing is written.
- R3: A single written byte lands at the 9-bit address formed from control bit [1] (high bit) and the word-address byte, once a Stop closes the transfer.
- R4: In a multi-byte write only the low 4 address bits advance, so the address wraps inside the 16-byte page. When more than 16 bytes are sent, the later bytes overwrite the earlier ones in the same page.
- R5: A random read (write header, address, repeated Start, read header) returns the stored byte at that address, MSB first.
- R6: A sequential read advances the full 9-bit address after every byte the controller acknowledges, and wraps from 511 to 0. After the controller's NACK the target keeps SDA released.
- R7: After a committing Stop the target ignores the bus for 16 + BUSY_CYCLES clocks. A control byte sent in that time gets no acknowledge.
- R8: With code 4'b1011 the address byte names a register. Writes to registers below NUM_CFG update that byte of the register port, writes at or above NUM_CFG are dropped, and reads there return 0.
- R9: A Stop in the middle of a data byte, or a Start while written bytes are pending, discards the whole pending write without starting an internal write cycle.
- R10: Each accepted control, address and written data byte is acknowledged by a low SDA during the ninth clock, and the output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low |
| strap_ba_i | input | 2 | Bus-select bits this target answers to |
| cfg_regs_o | output | NUM_CFG*8 | Configuration registers, register i in bits [8i+7:8i] |

## Verification
Full-page writes start at a mid-page slot in pages at both ends of the array and on either side of the ninth-bit boundary. Read back, they separate correct in-page wrapping from a carry into the page bits, and show whether the ninth bit is taken from the control byte. A 20-byte write tells overwrite-on-wrap apart from dropping the extra bytes, and a read across 511 shows whether the sequential address wraps. Single-byte writes over scattered addresses, probes sent during the busy window, headers with wrong codes or wrong bus-select bits, aborted transfers, and register writes both inside and past the bank separate committing from discarding and cover each address-space decode.

// File: rtl/i2cpm_pkg.sv
// Package: shared state encodings for the I2C paged memory target.
// Assumes: nothing beyond the importing modules.
package i2cpm_pkg;

    // Bus protocol state of the target
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } bus_state_t;

    // Phase of the page buffer commit engine
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SCAN,
        PH_HOLD
    } commit_phase_t;

endpackage

// File: rtl/i2cpm_bus_sense.sv
// Module: i2cpm_bus_sense
// Synchronises SCL and SDA to clk and produces one-cycle pulses for SCL
// rising/falling edges and for Start/Stop conditions.
// Assumes: the bus is much slower than clk, SYNC_STAGES >= 2, and both lines
// idle high.
module i2cpm_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Purpose: synchroniser chains plus one-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cpm_mem_array.sv
// Module: i2cpm_mem_array
// Byte-wide storage with one synchronous write port and one asynchronous
// read port.
// Assumes: contents are not reset; readers only use locations already written.
module i2cpm_mem_array #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    // Purpose: store one byte per write strobe
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/i2cpm_page_buf.sv
// Module: i2cpm_page_buf
// Gathers written bytes in slots of one page. On commit_req it walks every
// slot once, emits a write for each filled slot, then holds busy for
// BUSY_CYCLES clocks to stand for the internal write cycle.
// Assumes: push and clear arrive only while not busy; page_base and
// commit_cfg are stable when commit_req pulses.
module i2cpm_page_buf
    import i2cpm_pkg::*;
#(
    parameter int PW          = 4,
    parameter int AW          = 9,
    parameter int BUSY_CYCLES = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PW-1:0]    push_slot,
    input  logic [7:0]       push_data,
    input  logic             clear,
    input  logic             commit_req,
    input  logic [AW-PW-1:0] page_base,
    input  logic             commit_cfg,
    output logic             busy,
    output logic             mem_we,
    output logic             cfg_we,
    output logic [AW-1:0]    wr_addr,
    output logic [7:0]       wr_data
);

    localparam int PAGE  = 1 << PW;
    localparam int BW    = $clog2(BUSY_CYCLES + 1);
    localparam int BASEW = AW - PW;

    commit_phase_t     phase;
    logic [7:0]        slot_data [PAGE];
    logic [PAGE-1:0]   slot_full;
    logic [PW-1:0]     scan;
    logic [BW-1:0]     hold_cnt;
    logic [BASEW-1:0]  base_q;
    logic              cfg_q;
    logic              emit;

    // Purpose: capture pushed bytes into their page slot
    always_ff @(posedge clk) begin
        if (push && phase == PH_IDLE) begin
            slot_data[push_slot] <= push_data;
        end
    end

    // Purpose: slot occupancy, commit walk and busy hold sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            slot_full <= '0;
            scan      <= '0;
            hold_cnt  <= '0;
            base_q    <= '0;
            cfg_q     <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (clear) begin
                        slot_full <= '0;
                    end else if (push) begin
                        slot_full[push_slot] <= 1'b1;
                    end
                    if (commit_req) begin
                        base_q <= page_base;
                        cfg_q  <= commit_cfg;
                        scan   <= '0;
                        phase  <= PH_SCAN;
                    end
                end
                PH_SCAN: begin
                    slot_full[scan] <= 1'b0;
                    scan            <= scan + 1'b1;
                    if (scan == PW'(PAGE - 1)) begin
                        hold_cnt <= '0;
                        phase    <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    hold_cnt <= hold_cnt + 1'b1;
                    if (hold_cnt == BW'(BUSY_CYCLES - 1)) begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy    = (phase != PH_IDLE);
    assign emit    = (phase == PH_SCAN) && slot_full[scan];
    assign mem_we  = emit && !cfg_q;
    assign cfg_we  = emit && cfg_q;
    assign wr_addr = {base_q, scan};
    assign wr_data = slot_data[scan];

    AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> (slot_full != '0)); // R3
    AST_NO_PUSH_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !push); // R7

endmodule

// File: rtl/i2cpm_slave.sv
// Module: i2cpm_slave (top)
// I2C target for a 512-byte memory and NUM_CFG configuration registers.
// Decodes the control byte, loads the word address, gathers writes through
// the page buffer, and serves random and sequential reads.
// Assumes: SCL is slower than clk by at least 8x per phase; NUM_CFG is a power
// of two between 2 and 128; the ninth address bit travels in the control byte.
module i2cpm_slave
    import i2cpm_pkg::*;
#(
    parameter int         PW          = 4,
    parameter int         NUM_CFG     = 8,
    parameter int         BUSY_CYCLES = 300,
    parameter logic [3:0] MEM_CODE    = 4'b1010,
    parameter logic [3:0] CFG_CODE    = 4'b1011
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    input  logic [1:0]           strap_ba_i,
    output logic [NUM_CFG*8-1:0] cfg_regs_o
);

    localparam int AW = 9;
    localparam int CW = $clog2(NUM_CFG);

    // bus sense outputs
    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    // protocol state
    bus_state_t      state;
    logic [3:0]      bit_cnt;
    logic [7:0]      rx_sh;
    logic [7:0]      tx_sh;
    logic            oe;
    logic            rw_q;
    logic            cfg_sel;
    logic            a8_q;
    logic            nack_q;
    logic            pend;
    logic [AW-1:0]   ptr;
    logic [PW-1:0]   wr_slot;

    // buffer handshake
    logic            push_q, clear_q, commit_q;
    logic [PW-1:0]   push_slot_q;
    logic [7:0]      push_data_q;
    logic            busy, mem_we, cfg_we;
    logic [AW-1:0]   wr_addr;
    logic [7:0]      wr_data;

    // read path
    logic [7:0]      mem_rdata, cfg_rdata, rd_byte;
    logic [7:0]      cfg_q [NUM_CFG];

    logic            byte_done;
    logic [3:0]      ctl_code;
    logic            ctl_hit;

    i2cpm_bus_sense #(.SYNC_STAGES(2)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2cpm_page_buf #(.PW(PW), .AW(AW), .BUSY_CYCLES(BUSY_CYCLES)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_q),
        .push_slot  (push_slot_q),
        .push_data  (push_data_q),
        .clear      (clear_q),
        .commit_req (commit_q),
        .page_base  (ptr[AW-1:PW]),
        .commit_cfg (cfg_sel),
        .busy       (busy),
        .mem_we     (mem_we),
        .cfg_we     (cfg_we),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    i2cpm_mem_array #(.AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (ptr),
        .rdata (mem_rdata)
    );

    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign ctl_code  = rx_sh[7:4];
    assign ctl_hit   = ((ctl_code == MEM_CODE) || (ctl_code == CFG_CODE))
                       && (rx_sh[3:2] == strap_ba_i);
    assign cfg_rdata = (ptr[7:0] < 8'(NUM_CFG)) ? cfg_q[ptr[CW-1:0]] : 8'h00;
    assign rd_byte   = cfg_sel ? cfg_rdata : mem_rdata;
    assign sda_oe_o  = oe;

    // Purpose: configuration register bank, written by the commit walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CFG; i++) begin
                cfg_q[i] <= 8'h00;
            end
        end else if (cfg_we && (wr_addr[7:0] < 8'(NUM_CFG))) begin
            cfg_q[wr_addr[CW-1:0]] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg_out
        assign cfg_regs_o[g*8 +: 8] = cfg_q[g];
    end

    // Purpose: bus protocol engine (bytes in, bytes out, acknowledges, commit)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            oe          <= 1'b0;
            rw_q        <= 1'b0;
            cfg_sel     <= 1'b0;
            a8_q        <= 1'b0;
            nack_q      <= 1'b0;
            pend        <= 1'b0;
            ptr         <= '0;
            wr_slot     <= '0;
            push_q      <= 1'b0;
            clear_q     <= 1'b0;
            commit_q    <= 1'b0;
            push_slot_q <= '0;
            push_data_q <= '0;
        end else begin
            push_q   <= 1'b0;
            clear_q  <= 1'b0;
            commit_q <= 1'b0;
            if (busy) begin
                state <= ST_IGNORE;
                oe    <= 1'b0;
            end else if (start_evt) begin
                state   <= ST_CTRL;
                bit_cnt <= '0;
                oe      <= 1'b0;
                if (pend) begin
                    clear_q <= 1'b1;
                    pend    <= 1'b0;
                end
            end else if (stop_evt) begin
                state <= ST_IDLE;
                oe    <= 1'b0;
                if (pend) begin
                    // the Stop's own SCL rise counts as one sampled bit
                    if (state == ST_WDATA && bit_cnt <= 4'd1) begin
                        commit_q <= 1'b1;
                    end else begin
                        clear_q <= 1'b1;
                    end
                    pend <= 1'b0;
                end
            end else begin
                case (state)
                    ST_CTRL, ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_CTRL) begin
                                if (ctl_hit) begin
                                    oe      <= 1'b1;
                                    state   <= ST_CTRL_ACK;
                                    rw_q    <= rx_sh[0];
                                    cfg_sel <= (ctl_code == CFG_CODE);
                                    if (!rx_sh[0]) begin
                                        a8_q <= rx_sh[1] && (ctl_code == MEM_CODE);
                                    end
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_ADDR) begin
                                ptr     <= {a8_q, rx_sh};
                                wr_slot <= rx_sh[PW-1:0];
                                oe      <= 1'b1;
                                state   <= ST_ADDR_ACK;
                            end else begin
                                push_q      <= 1'b1;
                                push_slot_q <= wr_slot;
                                push_data_q <= rx_sh;
                                wr_slot     <= wr_slot + 1'b1;
                                pend        <= 1'b1;
                                oe          <= 1'b1;
                                state       <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_CTRL_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                tx_sh <= rd_byte;
                                oe    <= ~rd_byte[7];
                                state <= ST_RDATA;
                            end else begin
                                oe    <= 1'b0;
                                state <= ST_ADDR;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            oe      <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                oe    <= 1'b0;
                                state <= ST_RACK;
                            end else begin
                                tx_sh <= {tx_sh[6:0], 1'b0};
                                oe    <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_s;
                            if (!sda_s) begin
                                ptr <= ptr + 1'b1;
                            end
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (nack_q) begin
                                state <= ST_IGNORE;
                            end else begin
                                tx_sh <= rd_byte;
                                oe    <= ~rd_byte[7];
                                state <= ST_RDATA;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe) |-> !scl_s); // R10
    AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !oe); // R2
    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !sda_oe_o); // R7

endmodule

// File: tb/i2cpm_slave_bench.sv
// Bench: drives the bus as a controller, keeps a byte model of the memory and
// registers, and compares every returned byte and acknowledge with it.
module i2cpm_slave_bench;

    localparam int         NUM_CFG = 8;
    localparam int         BUSY    = 300;
    localparam int         PAGE    = 16;
    localparam int         Q       = 4;
    localparam logic [3:0] MEMC    = 4'b1010;
    localparam logic [3:0] CFGC    = 4'b1011;
    localparam logic [1:0] BA      = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NUM_CFG*8-1:0] cfg_regs;

    int n_vec = 0;
    int n_err = 0;
    logic [7:0] mem_m [512];
    logic [7:0] cfg_m [NUM_CFG];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2cpm_slave #(.NUM_CFG(NUM_CFG), .BUSY_CYCLES(BUSY)) u_i2cpm_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .strap_ba_i (BA),
        .cfg_regs_o (cfg_regs)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
        ack = ~sda_line;
        qw(); scl_m = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
            d = {d[6:0], sda_line};
            qw(); scl_m = 1'b0; qw();
        end
        send_bit(~give_ack);
    endtask

    function automatic logic [7:0] exp_byte(input logic [3:0] code, input logic [8:0] a);
        if (code == MEMC) return mem_m[a];
        if (a[7:0] < NUM_CFG) return cfg_m[a[2:0]];
        return 8'h00;
    endfunction

    task automatic do_write(input logic [3:0] code, input logic [8:0] addr, input int n,
                            input int seed, input bit probe);
        logic ack;
        logic [7:0] d;
        logic [8:0] a;
        bus_start();
        send_byte({code, BA, addr[8], 1'b0}, ack); chk("R10 control ack", ack, 1);
        send_byte(addr[7:0], ack); chk("R10 address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            d = 8'(seed + k * 29);
            send_byte(d, ack); chk("R10 data ack", ack, 1);
            a = {addr[8:4], 4'(addr[3:0] + k)};
            if (code == MEMC) mem_m[a] = d;
            else if (a < NUM_CFG) cfg_m[a[2:0]] = d;
        end
        bus_stop();
        if (probe) begin
            bus_start();
            send_byte({MEMC, BA, 1'b0, 1'b0}, ack); chk("R7 busy control NACK", ack, 0);
            bus_stop();
        end
        repeat (PAGE + BUSY + 40) @(negedge clk);
    endtask

    task automatic do_read(input logic [3:0] code, input logic [8:0] addr, input int n,
                           input string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({code, BA, addr[8], 1'b0}, ack); chk("R5 header ack", ack, 1);
        send_byte(addr[7:0], ack); chk("R5 address ack", ack, 1);
        bus_start();
        send_byte({code, BA, addr[8], 1'b1}, ack); chk("R5 read header ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            chk(tag, d, exp_byte(code, 9'(addr + k)));
        end
        chk("R6 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int pages [6] = '{0, 1, 15, 16, 30, 31};
        int singles [6] = '{2, 100, 255, 256, 300, 511};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 config port after reset", int'(cfg_regs == '0), 1);

        // R4: full pages starting mid-page, wrap inside page
        foreach (pages[i]) do_write(MEMC, 9'(pages[i] * 16 + 3), 16, pages[i] * 7 + 1, 1'b0);
        do_read(MEMC, 9'd0, 32, "R4 pages 0-1");
        do_read(MEMC, 9'd240, 32, "R4 pages 15-16 across ninth bit");
        do_read(MEMC, 9'd480, 32, "R4 pages 30-31");
        // R6: sequential read wraps 511 -> 0
        do_read(MEMC, 9'd504, 16, "R6 wrap 511 to 0");

        // R4: 20 bytes into one page overwrite the first four
        do_write(MEMC, 9'd80, 20, 77, 1'b0);
        do_read(MEMC, 9'd80, 16, "R4 overflow overwrite");

        // R3 / R5: single bytes
        foreach (singles[i]) begin
            do_write(MEMC, 9'(singles[i]), 1, singles[i] + 5, 1'b0);
            do_read(MEMC, 9'(singles[i]), 1, "R3 byte write readback");
        end

        // R7: probe during internal write cycle, then data intact
        do_write(MEMC, 9'd130, 3, 200, 1'b1);
        do_read(MEMC, 9'd130, 3, "R7 data after busy");

        // R2: wrong bus-select bits and wrong code are ignored
        bus_start();
        send_byte({MEMC, 2'b01, 1'b0, 1'b0}, ack); chk("R2 strap mismatch NACK", ack, 0);
        send_byte(8'd2, ack); send_byte(8'h5A, ack); bus_stop();
        repeat (20) @(negedge clk);
        bus_start();
        send_byte({4'b1001, BA, 1'b0, 1'b0}, ack); chk("R2 unknown code NACK", ack, 0);
        send_byte(8'd2, ack); send_byte(8'hA5, ack); bus_stop();
        repeat (PAGE + BUSY + 40) @(negedge clk);
        do_read(MEMC, 9'd2, 1, "R2 ignored write left data");

        // R9: Stop in mid data byte discards
        bus_start();
        send_byte({MEMC, BA, 1'b0, 1'b0}, ack);
        send_byte(8'd100, ack);
        send_byte(8'h3C, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        repeat (10) @(negedge clk);
        do_read(MEMC, 9'd100, 1, "R9 mid-byte Stop discards");
        // R9: repeated Start with pending data discards
        bus_start();
        send_byte({MEMC, BA, 1'b1, 1'b0}, ack);
        send_byte(8'd44, ack);
        send_byte(8'hC3, ack);
        bus_start();
        send_byte({MEMC, BA, 1'b1, 1'b1}, ack); chk("R9 no busy after discard", ack, 1);
        recv_byte(1'b0, d);
        chk("R9 Start discards pending", d, mem_m[9'd300]);
        bus_stop();

        // R8: configuration space
        do_write(CFGC, 9'd2, 3, 17, 1'b0);
        for (int i = 0; i < NUM_CFG; i++) chk("R8 register port", cfg_regs[i*8 +: 8], cfg_m[i]);
        do_read(CFGC, 9'd1, 5, "R8 register readback");
        do_write(CFGC, 9'd9, 1, 99, 1'b0);
        for (int i = 0; i < NUM_CFG; i++) chk("R8 out-of-bank write dropped", cfg_regs[i*8 +: 8], cfg_m[i]);
        do_read(CFGC, 9'd9, 1, "R8 out-of-bank read zero");

        finish_run();
    end

endmodule